// File: doc/BRIEF.md
# Cross-Domain Counter Snapshot with Four-Phase Handshake

A free-running binary counter advances on every edge of a reference clock. A reader in an unrelated host clock domain needs a coherent copy of the whole multi-bit value. Sampling the live counter directly across the boundary can tear bits. This block avoids that by freezing the counter into a holding register on the reference side. It then lets the host sample that register only once it is known to be stable.

The host pulses `rd_req` for one cycle while `busy` is low. The host side drives a request level. The request crosses into the reference domain through a synchronizer. On its rising edge the reference side copies the counter into the holding register, and in the same cycle it raises an acknowledge. The acknowledge returns through a second synchronizer. Only after that does the host capture the holding register into `snap_data` and pulse `snap_valid`.

The host then drops the request and keeps `busy` high until the acknowledge has returned low. Only then does it accept another read. With `WAIT_CYCLES` set above zero, the host captures after a fixed count of its own cycles instead of waiting for the acknowledge. It still completes the return-to-zero sequence before going idle.

The host controller has four states:
- `H_IDLE`: no read in progress.
- `H_REQ`: request high, waiting for the acknowledge or the timer.
- `H_ACK_HI`: fixed mode only; request already low, waiting for the late acknowledge to arrive.
- `H_ACK_LO`: request low, waiting for the acknowledge to fall.

It has five transitions:
- `H_IDLE`→`H_REQ` on `rd_req`.
- `H_REQ`→`H_ACK_LO` on capture when the synchronized acknowledge is already high.
- `H_REQ`→`H_ACK_HI` on capture in fixed mode when it is not.
- `H_ACK_HI`→`H_ACK_LO` when the acknowledge arrives.
- `H_ACK_LO`→`H_IDLE` when it falls.

Top module: `cdc_counter_snapshot`

## Requirements
- R1: While `host_rst_n` is low, `busy` and `snap_valid` are 0 and `snap_data` is all zeros.
- R2: A `rd_req` sampled high at a host edge while `busy` is low starts a read. `busy` is 1 from the following cycle.
- R3: `rd_req` pulses while `busy` is high are ignored. They produce no extra `snap_valid` pulse, and `busy` returns to 0 and stays 0 after the read in progress ends.
- R4: Each accepted read produces exactly one `snap_valid` pulse, one host cycle long. `snap_data` changes only in that cycle and holds its value until the next pulse.
- R5: The counter holds the number of reference clock edges since `ref_rst_n` was released, modulo 2^CNT_W. The captured value is at least the counter value when the read was accepted and below the value when `snap_valid` is seen, so successive snapshots strictly increase.
- R6: The holding register changes only on the rising edge of the synchronized request and keeps its value while the request stays high or low.
- R7: The handshake completes in four phases before the next read. The request rises only while the synchronized acknowledge is low, and `busy` stays 1 after `snap_valid` until the acknowledge has returned to 0.
- R8: With `WAIT_CYCLES` > 0, `snap_valid` rises exactly `WAIT_CYCLES` host cycles after the accepting edge, regardless of the acknowledge.
- R9: With `WAIT_CYCLES` = 0, `snap_valid` follows only a cycle in which the synchronized acknowledge was high, and never earlier than 4 host cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| host_clk | input | 1 | Host (reader) clock |
| host_rst_n | input | 1 | Active-low asynchronous reset, host domain |
| ref_clk | input | 1 | Reference clock that drives the counter |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| rd_req | input | 1 | One-cycle read strobe from the host |
| busy | output | 1 | High while a read handshake is in progress; the host read is stalled |
| snap_valid | output | 1 | One-cycle pulse when `snap_data` holds a new snapshot |
| snap_data | output | CNT_W | Captured counter value |

## Verification
The bench targets the following corner cases:
- **Capture window.** Each snapshot is checked against the window of reference edges between acceptance and `snap_valid`. A design that sampled the live counter too late, or read a stale holding register, falls outside that window or repeats the previous value.
- **Ignored strobes.** Strobes are injected both while the request is high and while the acknowledge is draining. A controller that queued or restarted on them would show a second pulse or a `busy` that rises again.
- **Return to zero.** `busy` is checked just after capture. A controller that skipped the return-to-zero phase would drop it early.
- **Fixed-wait latency.** In fixed-wait mode the capture latency is checked to the exact cycle. An off-by-one timer shows there directly.

// File: rtl/snap_pkg.sv
package snap_pkg;
    typedef enum logic [1:0] {
        H_IDLE   = 2'd0,
        H_REQ    = 2'd1,
        H_ACK_HI = 2'd2,
        H_ACK_LO = 2'd3
    } host_state_e;
endpackage

// File: rtl/snap_sync.sv
// Multi-flop level synchronizer into the clock domain of clk.
module snap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/snap_ref_side.sv
// Reference-domain side: live counter, holding register, acknowledge.
module snap_ref_side #(
    parameter int CNT_W = 32
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             req_sync,
    output logic             ack_lvl,
    output logic [CNT_W-1:0] hold_val
);
    logic [CNT_W-1:0] live_cnt;
    logic             req_edge;

    // ack_lvl is the previous synchronized request, so it doubles as the edge detector.
    assign req_edge = req_sync && !ack_lvl;

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            live_cnt <= '0;
            ack_lvl  <= 1'b0;
            hold_val <= '0;
        end else begin
            live_cnt <= live_cnt + 1'b1;
            ack_lvl  <= req_sync;
            if (req_edge) hold_val <= live_cnt;
        end
    end
endmodule

// File: rtl/snap_host_fsm.sv
// Host-domain controller for the request/acknowledge exchange.
module snap_host_fsm
    import snap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int WAIT_CYCLES = 0
) (
    input  logic             host_clk,
    input  logic             host_rst_n,
    input  logic             rd_req,
    input  logic             ack_sync,
    input  logic [CNT_W-1:0] hold_val,
    output logic             req_lvl,
    output logic             busy,
    output logic             snap_valid,
    output logic [CNT_W-1:0] snap_data
);
    localparam bit FIXED = (WAIT_CYCLES > 0);

    host_state_e state_q, state_d;
    logic        done;
    logic        capture;

    generate
        if (FIXED) begin : g_fixed
            localparam int TW = $clog2(WAIT_CYCLES + 1);
            logic [TW-1:0] timer_q;
            always_ff @(posedge host_clk or negedge host_rst_n) begin
                if (!host_rst_n)          timer_q <= '0;
                else if (state_q == H_REQ) timer_q <= timer_q + 1'b1;
                else                      timer_q <= '0;
            end
            assign done = (timer_q == TW'(WAIT_CYCLES - 1));
        end else begin : g_ack
            assign done = ack_sync;
        end
    endgenerate

    assign capture = (state_q == H_REQ) && done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE:   if (rd_req)   state_d = H_REQ;
            H_REQ:    if (capture)  state_d = ack_sync ? H_ACK_LO : H_ACK_HI;
            H_ACK_HI: if (ack_sync) state_d = H_ACK_LO;
            H_ACK_LO: if (!ack_sync) state_d = H_IDLE;
            default:                state_d = H_IDLE;
        endcase
    end

    always_ff @(posedge host_clk or negedge host_rst_n) begin
        if (!host_rst_n) state_q <= H_IDLE;
        else             state_q <= state_d;
    end

    always_ff @(posedge host_clk or negedge host_rst_n) begin
        if (!host_rst_n) begin
            snap_valid <= 1'b0;
            snap_data  <= '0;
        end else begin
            snap_valid <= capture;
            if (capture) snap_data <= hold_val;
        end
    end

    assign req_lvl = (state_q == H_REQ);
    assign busy    = (state_q != H_IDLE);
endmodule

// File: rtl/cdc_counter_snapshot.sv
module cdc_counter_snapshot #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_CYCLES = 0
) (
    input  logic             host_clk,
    input  logic             host_rst_n,
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             rd_req,
    output logic             busy,
    output logic             snap_valid,
    output logic [CNT_W-1:0] snap_data
);
    logic             req_lvl;
    logic             req_sync;
    logic             ack_lvl;
    logic             ack_sync;
    logic [CNT_W-1:0] hold_val;

    snap_host_fsm #(.CNT_W(CNT_W), .WAIT_CYCLES(WAIT_CYCLES)) u_host (
        .host_clk   (host_clk),
        .host_rst_n (host_rst_n),
        .rd_req     (rd_req),
        .ack_sync   (ack_sync),
        .hold_val   (hold_val),
        .req_lvl    (req_lvl),
        .busy       (busy),
        .snap_valid (snap_valid),
        .snap_data  (snap_data)
    );

    snap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .d     (req_lvl),
        .q     (req_sync)
    );

    snap_ref_side #(.CNT_W(CNT_W)) u_ref (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .req_sync  (req_sync),
        .ack_lvl   (ack_lvl),
        .hold_val  (hold_val)
    );

    snap_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (host_clk),
        .rst_n (host_rst_n),
        .d     (ack_lvl),
        .q     (ack_sync)
    );
endmodule

// File: rtl/snap_checker.sv
module snap_checker #(
    parameter int CNT_W       = 32,
    parameter int WAIT_CYCLES = 0
) (
    input logic             host_clk,
    input logic             host_rst_n,
    input logic             ref_clk,
    input logic             ref_rst_n,
    input logic             rd_req,
    input logic             busy,
    input logic             snap_valid,
    input logic [CNT_W-1:0] snap_data,
    input logic             req_lvl,
    input logic             ack_sync,
    input logic             req_sync,
    input logic             ack_lvl,
    input logic [CNT_W-1:0] hold_val
);
    p_busy_covers_req_r2: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        req_lvl |-> busy);

    p_rise_only_accepted_r3: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        $rose(req_lvl) |-> $past(rd_req && !busy));

    p_valid_pulse_r4: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        snap_valid |=> !snap_valid);

    p_data_hold_r4: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        !snap_valid |-> $stable(snap_data));

    p_hold_stable_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !(req_sync && !ack_lvl) |=> $stable(hold_val));

    p_req_rise_ack_low_r7: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        $rose(req_lvl) |-> !ack_sync);

    p_valid_in_busy_r7: assert property (@(posedge host_clk) disable iff (!host_rst_n)
        snap_valid |-> busy);

    generate
        if (WAIT_CYCLES > 0) begin : g_fixed
            logic [15:0] lat_cnt;
            always_ff @(posedge host_clk or negedge host_rst_n) begin
                if (!host_rst_n)  lat_cnt <= '0;
                else if (req_lvl) lat_cnt <= lat_cnt + 1'b1;
                else              lat_cnt <= '0;
            end
            p_fixed_latency_r8: assert property (@(posedge host_clk) disable iff (!host_rst_n)
                snap_valid |-> lat_cnt == 16'(WAIT_CYCLES));
        end else begin : g_ack
            p_valid_after_ack_r9: assert property (@(posedge host_clk) disable iff (!host_rst_n)
                snap_valid |-> $past(ack_sync));
            p_req_holds_to_ack_r7: assert property (@(posedge host_clk) disable iff (!host_rst_n)
                $fell(req_lvl) |-> ack_sync);
        end
    endgenerate
endmodule

bind cdc_counter_snapshot snap_checker #(.CNT_W(CNT_W), .WAIT_CYCLES(WAIT_CYCLES)) u_chk (
    .host_clk   (host_clk),
    .host_rst_n (host_rst_n),
    .ref_clk    (ref_clk),
    .ref_rst_n  (ref_rst_n),
    .rd_req     (rd_req),
    .busy       (busy),
    .snap_valid (snap_valid),
    .snap_data  (snap_data),
    .req_lvl    (req_lvl),
    .ack_sync   (ack_sync),
    .req_sync   (req_sync),
    .ack_lvl    (ack_lvl),
    .hold_val   (hold_val)
);

// File: tb/cdc_counter_snapshot_test.sv
module cdc_counter_snapshot_test;
    localparam int W   = 16;
    localparam int FXW = 16;

    logic host_clk = 1'b0;
    logic ref_clk  = 1'b0;
    logic host_rst_n = 1'b0;
    logic ref_rst_n  = 1'b0;
    logic rd_a = 1'b0;
    logic rd_f = 1'b0;
    logic busy_a, val_a, busy_f, val_f;
    logic [W-1:0] data_a, data_f;

    int total = 0;
    int bad   = 0;
    int ref_ticks = 0;
    int last_a = -1;
    int last_f = -1;

    always #2 host_clk = ~host_clk;
    always #5 ref_clk  = ~ref_clk;

    always @(posedge ref_clk) if (ref_rst_n) ref_ticks <= ref_ticks + 1;

    cdc_counter_snapshot #(.CNT_W(W), .WAIT_CYCLES(0)) uut (
        .host_clk(host_clk), .host_rst_n(host_rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .rd_req(rd_a), .busy(busy_a), .snap_valid(val_a), .snap_data(data_a));

    cdc_counter_snapshot #(.CNT_W(W), .WAIT_CYCLES(FXW)) uut_fx (
        .host_clk(host_clk), .host_rst_n(host_rst_n), .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
        .rd_req(rd_f), .busy(busy_f), .snap_valid(val_f), .snap_data(data_f));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic busy_of(input bit fx);
        return fx ? busy_f : busy_a;
    endfunction
    function automatic logic val_of(input bit fx);
        return fx ? val_f : val_a;
    endfunction
    function automatic int data_of(input bit fx);
        return fx ? int'(data_f) : int'(data_a);
    endfunction

    task automatic setrd(input bit fx, input logic b);
        if (fx) rd_f = b; else rd_a = b;
    endtask

    task automatic do_read(input bit fx, input bit poke);
        int lo, hi, n, v, last;
        @(negedge host_clk);
        setrd(fx, 1'b1);
        @(posedge host_clk);
        @(negedge host_clk);
        setrd(fx, 1'b0);
        lo = ref_ticks;
        check(busy_of(fx) == 1'b1, "R2 busy after accept", busy_of(fx), 1);
        n = 0;
        while (!val_of(fx) && n < 100) begin
            if (poke && n == 2) setrd(fx, 1'b1);   // R3 strobe while request is high
            if (poke && n == 3) setrd(fx, 1'b0);
            @(negedge host_clk);
            n++;
        end
        hi = ref_ticks;
        v  = data_of(fx);
        last = fx ? last_f : last_a;
        check(val_of(fx) == 1'b1, "R4 valid pulse seen", val_of(fx), 1);
        if (fx) check(n == FXW, "R8 fixed latency", n, FXW);
        else    check(n >= 4 && n < 60, "R9 ack-mode latency", n, 4);
        check(v >= lo && v < hi, "R5 value in window (low bound)", v, lo);
        check(v > last, "R5 strictly increasing", v, last + 1);
        if (fx) last_f = v; else last_a = v;
        @(negedge host_clk);
        check(val_of(fx) == 1'b0, "R4 single-cycle valid", val_of(fx), 0);
        check(data_of(fx) == v, "R4 data held", data_of(fx), v);
        check(busy_of(fx) == 1'b1, "R7 busy held for return to zero", busy_of(fx), 1);
        n = 0;
        while (busy_of(fx) && n < 200) begin
            if (poke && n == 0) setrd(fx, 1'b1);   // R3 strobe while acknowledge drains
            if (poke && n == 1) setrd(fx, 1'b0);
            @(negedge host_clk);
            n++;
        end
        check(busy_of(fx) == 1'b0, "R7 handshake completes", busy_of(fx), 0);
        if (poke) begin
            repeat (4) begin
                @(negedge host_clk);
                check(busy_of(fx) == 1'b0, "R3 no restart from ignored strobe", busy_of(fx), 0);
                check(val_of(fx) == 1'b0, "R3 no extra valid", val_of(fx), 0);
            end
        end
        check(data_of(fx) == v, "R4 data held until next capture", data_of(fx), v);
    endtask

    initial begin
        repeat (3) @(negedge host_clk);
        // R1 reset state
        check(busy_a == 1'b0 && busy_f == 1'b0, "R1 busy in reset", busy_a, 0);
        check(val_a == 1'b0 && val_f == 1'b0, "R1 valid in reset", val_a, 0);
        check(data_a == '0 && data_f == '0, "R1 data in reset", int'(data_a), 0);
        @(negedge host_clk);
        host_rst_n = 1'b1;
        ref_rst_n  = 1'b1;
        repeat (5) @(negedge host_clk);
        for (int gap = 0; gap < 8; gap++) begin
            do_read(1'b0, gap[0]);
            repeat (gap) @(negedge host_clk);
        end
        for (int gap = 0; gap < 8; gap++) begin
            do_read(1'b1, gap[0]);
            repeat (gap) @(negedge host_clk);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule